// File: doc/BRIEF.md
# Machine Timer Interrupt CSR Unit

This unit holds a free-running 64-bit real-time counter, a 64-bit timer compare value, and the machine interrupt pending and enable registers of a processor hart. Software reaches them through a single-cycle CSR port. A write is applied at the clock edge while `csr_we` is high. The read data is combinational from the address.

The compare value is split into two 32-bit halves, so a 32-bit datapath can load the whole value. Once the counter reaches the compare value, a sticky timer-pending bit sets. Only a write to either compare half clears it. The unit masks the software and timer pending bits with their enables and adds a host request, which is raised while the host-message input is nonzero. It then picks one cause by fixed priority. A global machine interrupt-enable input gates the final request.

Top module: `mtimer_csr_unit`

## Requirements
- R1: After reset, the counter reads 0, both compare halves read 0xFFFFFFFF, the pending and enable registers read 0, and `irq_valid` is low while `host_msg` is 0.
- R2: The counter increments by one at each clock edge where `tick_en` is high and holds otherwise. Its low half is read at address 0x7A0 and its high half at 0x7A1. Writes to these addresses are ignored.
- R3: Pending bit 7 (timer) sets at the edge after the registered counter is greater than or equal to the registered 64-bit compare value, using an unsigned comparison. It then stays set until a compare write.
- R4: A write to the compare low half (0x321) or high half (0x361) loads that half and clears pending bit 7 at the same edge, and this clear overrides a set. The comparison uses the new value from the following cycle.
- R5: A write to the pending register (0x344) updates only bits 1, 3 and 5. Bit 7 and all other bits keep their value.
- R6: A write to the enable register (0x304) updates only bits 1, 3, 5 and 7. All other bits stay 0.
- R7: The software source is active when pending bit 3 and enable bit 3 are both set. The timer source is active when pending bit 7 and enable bit 7 are both set. The host source is active when `host_msg` is nonzero.
- R8: When several sources are active, the cause is software (code 0) first, then timer (code 1), then host (code 2). `irq_cause` reads 0 whenever `irq_valid` is low.
- R9: While `mie_global` is low, `irq_valid` is low whatever the sources are.
- R10: A read from any address other than the six listed returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| host_msg | input | 32 | Host message level; nonzero requests an interrupt |
| mie_global | input | 1 | Global machine interrupt enable |
| irq_valid | output | 1 | An enabled interrupt is selected |
| irq_cause | output | 2 | Selected cause code |

## Verification
A compare write can land in the same cycle in which the counter already meets or passes the compare value, so the hardware set and the software clear of the timer bit collide. The bench provokes this directly. It rewrites the low half with the current counter value while the bit is already set. The next cycle must show the bit clear, and the cycle after must show it set again. Random traffic keeps the compare values close to the counter, so collisions of writes to the pending register with a timer hit also occur often. A per-cycle reference model judges every read and interrupt output.

// File: rtl/mtcsr_pkg.sv
package mtcsr_pkg;

    localparam logic [11:0] A_IE     = 12'h304;
    localparam logic [11:0] A_CMP_LO = 12'h321;
    localparam logic [11:0] A_IP     = 12'h344;
    localparam logic [11:0] A_CMP_HI = 12'h361;
    localparam logic [11:0] A_RTC_LO = 12'h7A0;
    localparam logic [11:0] A_RTC_HI = 12'h7A1;

    localparam int B_SSW = 1;
    localparam int B_MSW = 3;
    localparam int B_STM = 5;
    localparam int B_MTM = 7;

    typedef enum logic [1:0] {
        CAUSE_SW   = 2'd0,
        CAUSE_TMR  = 2'd1,
        CAUSE_HOST = 2'd2
    } cause_e;

endpackage

// File: rtl/mtcsr_rtc.sv
module mtcsr_rtc #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] rtc_o
);
    logic [CNT_W-1:0] rtc_d, rtc_q;

    always_comb begin
        rtc_d = rtc_q + CNT_W'(tick_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rtc_q <= '0;
        else        rtc_q <= rtc_d;
    end

    assign rtc_o = rtc_q;
endmodule

// File: rtl/mtcsr_cmp.sv
module mtcsr_cmp #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [XLEN-1:0]   wdata,
    input  logic [2*XLEN-1:0] rtc_i,
    output logic [2*XLEN-1:0] cmp_o,
    output logic              hit_o
);
    localparam int CNT_W = 2 * XLEN;

    logic [CNT_W-1:0] cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (wr_lo) cmp_d[XLEN-1:0]     = wdata;
        if (wr_hi) cmp_d[CNT_W-1:XLEN] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '1;
        else        cmp_q <= cmp_d;
    end

    assign cmp_o = cmp_q;
    assign hit_o = (rtc_i >= cmp_q);
endmodule

// File: rtl/mtcsr_prio.sv
module mtcsr_prio
    import mtcsr_pkg::*;
(
    input  logic       gie,
    input  logic       sw_req,
    input  logic       tmr_req,
    input  logic       host_req,
    output logic       valid_o,
    output logic [1:0] cause_o
);
    cause_e sel;

    always_comb begin
        sel     = CAUSE_SW;
        valid_o = 1'b0;
        if (gie) begin
            if (sw_req) begin
                sel     = CAUSE_SW;
                valid_o = 1'b1;
            end else if (tmr_req) begin
                sel     = CAUSE_TMR;
                valid_o = 1'b1;
            end else if (host_req) begin
                sel     = CAUSE_HOST;
                valid_o = 1'b1;
            end
        end
        cause_o = valid_o ? sel : CAUSE_SW;
    end
endmodule

// File: rtl/mtimer_csr_unit.sv
module mtimer_csr_unit
    import mtcsr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic [XLEN-1:0]   host_msg,
    input  logic              mie_global,
    output logic              irq_valid,
    output logic [1:0]        irq_cause
);
    localparam int CNT_W = 2 * XLEN;
    localparam logic [XLEN-1:0] IP_SW_MASK =
        (XLEN'(1) << B_SSW) | (XLEN'(1) << B_MSW) | (XLEN'(1) << B_STM);
    localparam logic [XLEN-1:0] IE_MASK = IP_SW_MASK | (XLEN'(1) << B_MTM);

    typedef struct packed {
        logic [XLEN-1:0] ip;
        logic [XLEN-1:0] ie;
    } irq_regs_t;

    irq_regs_t st_d, st_q;

    logic [CNT_W-1:0] rtc_q;
    logic [CNT_W-1:0] cmp_q;
    logic             cmp_hit;
    logic             wr_cmp_lo, wr_cmp_hi, wr_ip, wr_ie;
    logic [XLEN-1:0]  ip_q, ie_q;

    assign wr_cmp_lo = csr_we && (csr_addr == ADDR_W'(A_CMP_LO));
    assign wr_cmp_hi = csr_we && (csr_addr == ADDR_W'(A_CMP_HI));
    assign wr_ip     = csr_we && (csr_addr == ADDR_W'(A_IP));
    assign wr_ie     = csr_we && (csr_addr == ADDR_W'(A_IE));

    mtcsr_rtc #(.CNT_W(CNT_W)) rtc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .rtc_o   (rtc_q)
    );

    mtcsr_cmp #(.XLEN(XLEN)) cmp_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_cmp_lo),
        .wr_hi (wr_cmp_hi),
        .wdata (csr_wdata),
        .rtc_i (rtc_q),
        .cmp_o (cmp_q),
        .hit_o (cmp_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ip) st_d.ip = (st_q.ip & ~IP_SW_MASK) | (csr_wdata & IP_SW_MASK);
        if (wr_ie) st_d.ie = (st_q.ie & ~IE_MASK) | (csr_wdata & IE_MASK);
        if (wr_cmp_lo || wr_cmp_hi) st_d.ip[B_MTM] = 1'b0;
        else if (cmp_hit)           st_d.ip[B_MTM] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ip_q = st_q.ip;
    assign ie_q = st_q.ie;

    always_comb begin
        csr_rdata = '0;
        if      (csr_addr == ADDR_W'(A_IP))     csr_rdata = ip_q;
        else if (csr_addr == ADDR_W'(A_IE))     csr_rdata = ie_q;
        else if (csr_addr == ADDR_W'(A_CMP_LO)) csr_rdata = cmp_q[XLEN-1:0];
        else if (csr_addr == ADDR_W'(A_CMP_HI)) csr_rdata = cmp_q[CNT_W-1:XLEN];
        else if (csr_addr == ADDR_W'(A_RTC_LO)) csr_rdata = rtc_q[XLEN-1:0];
        else if (csr_addr == ADDR_W'(A_RTC_HI)) csr_rdata = rtc_q[CNT_W-1:XLEN];
    end

    mtcsr_prio prio_i (
        .gie      (mie_global),
        .sw_req   (ip_q[B_MSW] & ie_q[B_MSW]),
        .tmr_req  (ip_q[B_MTM] & ie_q[B_MTM]),
        .host_req (|host_msg),
        .valid_o  (irq_valid),
        .cause_o  (irq_cause)
    );
endmodule

// File: rtl/mtcsr_chk.sv
module mtcsr_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              mie_global,
    input logic              irq_valid,
    input logic [1:0]        irq_cause,
    input logic [XLEN-1:0]   ip_q,
    input logic [XLEN-1:0]   ie_q,
    input logic [2*XLEN-1:0] rtc_q,
    input logic [2*XLEN-1:0] cmp_q
);
    logic cmp_wr;
    assign cmp_wr = csr_we && (csr_addr == ADDR_W'(12'h321) || csr_addr == ADDR_W'(12'h361));

    AST_RTC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> rtc_q == $past(rtc_q) + 1'b1);                               // R2
    AST_RTC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(rtc_q));                                            // R2
    AST_MTIP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_q >= cmp_q) && !cmp_wr |=> ip_q[7]);                                // R3
    AST_MTIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ip_q[7] && !cmp_wr |=> ip_q[7]);                                         // R3
    AST_CMP_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !ip_q[7]);                                                    // R4
    AST_IP_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q & ~XLEN'(32'hAA)) == '0);                                          // R5
    AST_IE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q & ~XLEN'(32'hAA)) == '0);                                          // R6
    AST_SW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mie_global && ip_q[3] && ie_q[3] |-> irq_valid && irq_cause == 2'd0);    // R8
    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cause != 2'd3);                                                      // R8
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_global |-> !irq_valid);                                             // R9
endmodule

bind mtimer_csr_unit mtcsr_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .mie_global (mie_global),
    .irq_valid  (irq_valid),
    .irq_cause  (irq_cause),
    .ip_q       (ip_q),
    .ie_q       (ie_q),
    .rtc_q      (rtc_q),
    .cmp_q      (cmp_q)
);

// File: tb/mtimer_csr_unit_tb_top.sv
`timescale 1ns/1ps
module mtimer_csr_unit_tb_top;
    localparam logic [11:0] T_IE = 12'h304, T_CLO = 12'h321, T_IP = 12'h344;
    localparam logic [11:0] T_CHI = 12'h361, T_TLO = 12'h7A0, T_THI = 12'h7A1;
    localparam logic [11:0] T_BAD = 12'h123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] host_msg = '0;
    logic        mie_global = 1'b0;
    logic        irq_valid;
    logic [1:0]  irq_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_time, m_cmp;
    logic [31:0] m_ip, m_ie;

    always #4 clk = ~clk;

    mtimer_csr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .csr_addr(csr_addr),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .host_msg(host_msg), .mie_global(mie_global),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd_exp(input logic [11:0] a);
        case (a)
            T_IP:    return m_ip;
            T_IE:    return m_ie;
            T_CLO:   return m_cmp[31:0];
            T_CHI:   return m_cmp[63:32];
            T_TLO:   return m_time[31:0];
            T_THI:   return m_time[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [11:0] a);
        case (a)
            T_IP:          return "R5";
            T_IE:          return "R6";
            T_CLO, T_CHI:  return "R4";
            T_TLO, T_THI:  return "R2";
            default:       return "R10";
        endcase
    endfunction

    // One cycle: drive after the falling edge, check outputs, then advance the model at the rising edge.
    task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] wd,
                       input logic tk, input logic [31:0] hm, input logic g);
        logic sw, tm, hs, ev, hit, cw;
        logic [1:0] ec;
        logic [63:0] n_cmp;
        logic [31:0] n_ip, n_ie;
        @(negedge clk);
        csr_we = we; csr_addr = a; csr_wdata = wd; tick_en = tk; host_msg = hm; mie_global = g;
        #1;
        sw = m_ip[3] & m_ie[3];
        tm = m_ip[7] & m_ie[7];
        hs = (hm != 0);
        ev = g && (sw || tm || hs);
        ec = !ev ? 2'd0 : sw ? 2'd0 : tm ? 2'd1 : 2'd2;
        chk(g ? "R7" : "R9", {31'b0, irq_valid}, {31'b0, ev});
        chk("R8", {30'b0, irq_cause}, {30'b0, ec});
        chk(rd_tag(a), csr_rdata, rd_exp(a));
        @(posedge clk);
        hit = (m_time >= m_cmp);
        cw = 1'b0;
        n_cmp = m_cmp; n_ip = m_ip; n_ie = m_ie;
        if (we) begin
            case (a)
                T_CLO: begin n_cmp[31:0]  = wd; cw = 1'b1; end
                T_CHI: begin n_cmp[63:32] = wd; cw = 1'b1; end
                T_IP:  n_ip = (m_ip & ~32'h2A) | (wd & 32'h2A);
                T_IE:  n_ie = (m_ie & ~32'hAA) | (wd & 32'hAA);
                default: ;
            endcase
        end
        n_ip[7] = cw ? 1'b0 : (m_ip[7] | hit);
        m_cmp = n_cmp; m_ip = n_ip; m_ie = n_ie;
        m_time = m_time + 64'(tk);
    endtask

    task automatic rd(input logic [11:0] a, input logic tk);
        cyc(1'b0, a, 32'h0, tk, 32'h0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all R): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250705));
        m_time = '0; m_cmp = '1; m_ip = '0; m_ie = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        #1;
        chk("R1", {31'b0, irq_valid}, 32'h0);
        rd(T_TLO, 1'b0); rd(T_THI, 1'b0); rd(T_CLO, 1'b0); rd(T_CHI, 1'b0);
        rd(T_IP, 1'b0);  rd(T_IE, 1'b0);  rd(T_BAD, 1'b0);

        // R2: counter steps only with tick_en; writes to it ignored
        for (int i = 0; i < 6; i++) rd(T_TLO, i[0]);
        cyc(1'b1, T_TLO, 32'hDEAD_BEEF, 1'b1, 32'h0, 1'b1);
        rd(T_TLO, 1'b0);
        chk("R2", csr_rdata, m_time[31:0]);

        // R6: enable write sets only 1,3,5,7
        cyc(1'b1, T_IE, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1);
        rd(T_IE, 1'b0);
        chk("R6", csr_rdata, 32'h0000_00AA);

        // R3: equality boundary, then sticky
        cyc(1'b1, T_CHI, 32'h0, 1'b1, 32'h0, 1'b1);
        cyc(1'b1, T_CLO, m_time[31:0] + 32'd4, 1'b1, 32'h0, 1'b1);
        for (int i = 0; i < 8; i++) rd(T_IP, 1'b1);
        chk("R3", csr_rdata & 32'h80, 32'h80);

        // R4: compare write colliding with a hit clears first, then re-sets
        cyc(1'b1, T_CLO, m_time[31:0], 1'b0, 32'h0, 1'b1);
        rd(T_IP, 1'b0);
        chk("R4", csr_rdata & 32'h80, 32'h0);
        rd(T_IP, 1'b0);
        chk("R4", csr_rdata & 32'h80, 32'h80);

        // R5: pending writes cannot touch bit 7
        cyc(1'b1, T_IP, 32'h0, 1'b0, 32'h0, 1'b1);
        rd(T_IP, 1'b0);
        chk("R5", csr_rdata, 32'h80);
        cyc(1'b1, T_IP, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1);
        rd(T_IP, 1'b0);
        chk("R5", csr_rdata, 32'hAA);

        // R8/R9: priority walk-down with all sources active
        cyc(1'b0, T_IP, 32'h0, 1'b0, 32'h1, 1'b1);
        chk("R8", {30'b0, irq_cause}, 32'd0);
        cyc(1'b1, T_IP, 32'h0, 1'b0, 32'h1, 1'b1);
        cyc(1'b0, T_IP, 32'h0, 1'b0, 32'h1, 1'b1);
        chk("R8", {30'b0, irq_cause}, 32'd1);
        cyc(1'b1, T_IE, 32'h0, 1'b0, 32'h1, 1'b1);
        cyc(1'b0, T_IP, 32'h0, 1'b0, 32'h8000_0000, 1'b1);
        chk("R8", {30'b0, irq_cause}, 32'd2);
        cyc(1'b0, T_IP, 32'h0, 1'b0, 32'h8000_0000, 1'b0);
        chk("R9", {31'b0, irq_valid}, 32'h0);

        // Random traffic with compare values kept near the counter
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic [31:0] wd;
            int unsigned r;
            r = $urandom % 7;
            case (r)
                0: a = T_IP; 1: a = T_IE; 2: a = T_CLO; 3: a = T_CHI;
                4: a = T_TLO; 5: a = T_THI; default: a = T_BAD;
            endcase
            wd = $urandom;
            if (a == T_CLO) wd = m_time[31:0] + ($urandom % 48) - 32'd16;
            if (a == T_CHI && ($urandom % 4) != 0) wd = 32'h0;
            cyc(($urandom % 3) == 0, a, wd, ($urandom % 4) != 0,
                (($urandom % 8) == 0) ? $urandom | 32'h1 : 32'h0,
                ($urandom % 8) != 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule